// File: doc/BRIEF.md
# CAM Host Bus Front End and Register Loader

This block sits between a 16-bit host bus and a 64-bit content-addressable memory core. Each host access is qualified by a strobe and classified by two control lines, a write-not line and a command-not line, into one of four cycle types. Command writes carry a 16-bit instruction that picks the internal register that later data writes fill, or asks for a compare directly. Data writes arrive 16 bits at a time and are gathered into a 64-bit comparand, one of two mask registers, or the control register.

A completed load of any of these registers raises a one-cycle compare request toward the core, so the host never has to send a separate command after changing the search key or masks. Each mask register is steered by a control bit either into the compare mask or into the write mask handed to the core. Reads return either a status word (match flag, multiple-match flag, match address) or the associated data of the last match, one 16-bit word per read.

Top module: `cam_host_if`

## Requirements
- R1: A cycle is taken only on a clock edge where `host_strobe` is high; {`host_wr_n`,`host_cmd_n`} = 00 is a command write, 01 a data write, 10 a command read, 11 a data read. With the strobe low, no register, counter or output changes.
- R2: Four data writes, least significant word first, fill the selected 64-bit register; the register output takes the whole new value on the clock edge that captures the fourth word.
- R3: After one to three data writes the selected register output is unchanged; a command write in between clears the word count and discards the partial words.
- R4: The clock edge that captures the fourth word of any register load raises `cmp_req` for exactly one cycle; earlier words never raise it.
- R5: A command write of 0x0005 raises `cmp_req` for one cycle and changes none of the four registers or the write target.
- R6: Command codes 0x0001, 0x0002, 0x0003 and 0x0004 select the comparand, mask A, mask B and control register as write target; after reset the target is the comparand.
- R7: Any other command code raises no `cmp_req` and leaves the write target as it was; it still clears the word count like every command write.
- R8: A command read sets `host_rdata` on the capturing edge to bit 15 = `core_match`, bit 14 = `core_multi`, bits 9..0 = `core_addr`, other bits zero; `host_rdata` only changes on read cycles.
- R9: Successive data reads return `core_assoc` words 0,1,2,3 (least significant first) and then wrap; any command write restarts the sequence at word 0.
- R10: Control bit 0 steers mask A and control bit 1 steers mask B: 0 sends the mask to `cmp_mask_o`, 1 sends it to `wr_mask_o`; each output is the OR of the masks steered to it, zero if none.
- R11: Synchronous reset clears all four registers, `cmp_req`, `host_rdata` and both word counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_strobe | input | 1 | Qualifies a host cycle on this clock edge |
| host_wr_n | input | 1 | Low for write cycles, high for read cycles |
| host_cmd_n | input | 1 | Low for command cycles, high for data cycles |
| host_wdata | input | 16 | Host write data or instruction code |
| host_rdata | output | 16 | Registered read data (status or associated data word) |
| cmp_req | output | 1 | One-cycle compare request to the CAM core |
| comparand_o | output | 64 | Comparand register |
| mask_a_o | output | 64 | Mask register A |
| mask_b_o | output | 64 | Mask register B |
| ctrl_o | output | 64 | Control register |
| cmp_mask_o | output | 64 | Masks steered to compare use |
| wr_mask_o | output | 64 | Masks steered to write use |
| core_match | input | 1 | Match flag from the core |
| core_multi | input | 1 | Multiple-match flag from the core |
| core_addr | input | 10 | Match address from the core |
| core_assoc | input | 64 | Associated data of the matching entry |

## Verification
The hardest state to reach from the ports is a load interrupted part-way: some words sit in the staging register, invisible at the outputs, and only the result of the next full load shows whether they were discarded. The bench writes one to three words, issues a command write (including an unknown code), then completes a fresh four-word load and compares the register against values built only from the new words. The same approach covers a data-read sequence broken by a command write, checked by the word that the next read returns.

// File: rtl/cam_host_pkg.sv
package cam_host_pkg;

  // Cycle type, encoded as {wr_n, cmd_n}
  typedef enum logic [1:0] {
    CYC_CMD_WR  = 2'b00,
    CYC_DATA_WR = 2'b01,
    CYC_CMD_RD  = 2'b10,
    CYC_DATA_RD = 2'b11
  } cyc_e;

  // Register that data writes fill; value doubles as bank index
  typedef enum logic [1:0] {
    TGT_CMP  = 2'd0,
    TGT_MSKA = 2'd1,
    TGT_MSKB = 2'd2,
    TGT_CTRL = 2'd3
  } tgt_e;

  localparam int NUM_TGT = 4;

  localparam logic [15:0] OP_SEL_CMP  = 16'h0001;
  localparam logic [15:0] OP_SEL_MSKA = 16'h0002;
  localparam logic [15:0] OP_SEL_MSKB = 16'h0003;
  localparam logic [15:0] OP_SEL_CTRL = 16'h0004;
  localparam logic [15:0] OP_COMPARE  = 16'h0005;

  // Control-register bits steering the masks (0 = compare, 1 = write)
  localparam int CTRL_ROLE_A = 0;
  localparam int CTRL_ROLE_B = 1;

endpackage

// File: rtl/cam_cycle_decode.sv
module cam_cycle_decode
  import cam_host_pkg::*;
(
  input  logic strobe,
  input  logic wr_n,
  input  logic cmd_n,
  output logic cmd_wr,
  output logic data_wr,
  output logic cmd_rd,
  output logic data_rd
);

  cyc_e cyc;

  always_comb begin
    cyc     = cyc_e'({wr_n, cmd_n});
    cmd_wr  = 1'b0;
    data_wr = 1'b0;
    cmd_rd  = 1'b0;
    data_rd = 1'b0;
    if (strobe) begin
      unique case (cyc)
        CYC_CMD_WR:  cmd_wr  = 1'b1;
        CYC_DATA_WR: data_wr = 1'b1;
        CYC_CMD_RD:  cmd_rd  = 1'b1;
        CYC_DATA_RD: data_rd = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cam_reg_loader.sv
module cam_reg_loader
  import cam_host_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [DATA_W-1:0] comparand,
  output logic [DATA_W-1:0] mask_a,
  output logic [DATA_W-1:0] mask_b,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] cmp_mask,
  output logic [DATA_W-1:0] wr_mask,
  output logic              cmp_req
);

  localparam int WORDS   = DATA_W / BUS_W;
  localparam int CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int STAGE_W = DATA_W - BUS_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0]   wcnt;
  logic [STAGE_W-1:0] stage;
  tgt_e               target;
  logic [DATA_W-1:0]  bank [NUM_TGT];
  logic               commit;

  // Instruction decode
  logic sel_hit, cmp_hit;
  tgt_e sel_tgt;

  always_comb begin
    sel_hit = 1'b1;
    cmp_hit = 1'b0;
    sel_tgt = TGT_CMP;
    if (wdata == BUS_W'(OP_SEL_CMP))       sel_tgt = TGT_CMP;
    else if (wdata == BUS_W'(OP_SEL_MSKA)) sel_tgt = TGT_MSKA;
    else if (wdata == BUS_W'(OP_SEL_MSKB)) sel_tgt = TGT_MSKB;
    else if (wdata == BUS_W'(OP_SEL_CTRL)) sel_tgt = TGT_CTRL;
    else begin
      sel_hit = 1'b0;
      cmp_hit = (wdata == BUS_W'(OP_COMPARE));
    end
  end

  assign commit = data_wr && (wcnt == LAST);

  // Word counter, staging, target and compare request
  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      stage   <= '0;
      target  <= TGT_CMP;
      cmp_req <= 1'b0;
    end else begin
      cmp_req <= 1'b0;
      if (cmd_wr) begin
        wcnt <= '0;
        if (sel_hit) target <= sel_tgt;
        if (cmp_hit) cmp_req <= 1'b1;
      end else if (data_wr) begin
        if (wcnt == LAST) begin
          wcnt    <= '0;
          cmp_req <= 1'b1;
        end else begin
          stage[int'(wcnt)*BUS_W +: BUS_W] <= wdata;
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  // One 64-bit register per target, written whole on commit
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= '0;
      end else if (commit && (target == tgt_e'(g))) begin
        bank[g] <= {wdata, stage};
      end
    end
  end

  assign comparand = bank[TGT_CMP];
  assign mask_a    = bank[TGT_MSKA];
  assign mask_b    = bank[TGT_MSKB];
  assign ctrl      = bank[TGT_CTRL];

  // Mask steering
  always_comb begin
    cmp_mask = '0;
    wr_mask  = '0;
    if (ctrl[CTRL_ROLE_A]) wr_mask = wr_mask | mask_a;
    else                   cmp_mask = cmp_mask | mask_a;
    if (ctrl[CTRL_ROLE_B]) wr_mask = wr_mask | mask_b;
    else                   cmp_mask = cmp_mask | mask_b;
  end

endmodule

// File: rtl/cam_status_mux.sv
module cam_status_mux #(
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic              data_rd,
  input  logic              core_match,
  input  logic              core_multi,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_assoc,
  output logic [BUS_W-1:0]  rdata
);

  localparam int WORDS = DATA_W / BUS_W;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  // Address must leave the two top bits for the flags
  if (ADDR_W > BUS_W - 2) begin : g_bad_addr_w
    $error("ADDR_W too wide for status word");
  end

  logic [CNT_W-1:0] rcnt;
  logic [BUS_W-1:0] status_word;

  always_comb begin
    status_word             = '0;
    status_word[BUS_W-1]    = core_match;
    status_word[BUS_W-2]    = core_multi;
    status_word[ADDR_W-1:0] = core_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt  <= '0;
      rdata <= '0;
    end else begin
      if (cmd_wr) begin
        rcnt <= '0;
      end else if (cmd_rd) begin
        rdata <= status_word;
      end else if (data_rd) begin
        rdata <= core_assoc[int'(rcnt)*BUS_W +: BUS_W];
        rcnt  <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cam_host_if.sv
module cam_host_if #(
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_strobe,
  input  logic              host_wr_n,
  input  logic              host_cmd_n,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic [BUS_W-1:0]  host_rdata,
  output logic              cmp_req,
  output logic [DATA_W-1:0] comparand_o,
  output logic [DATA_W-1:0] mask_a_o,
  output logic [DATA_W-1:0] mask_b_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cmp_mask_o,
  output logic [DATA_W-1:0] wr_mask_o,
  input  logic              core_match,
  input  logic              core_multi,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_assoc
);

  logic cmd_wr, data_wr, cmd_rd, data_rd;

  cam_cycle_decode u_dec (
    .strobe  (host_strobe),
    .wr_n    (host_wr_n),
    .cmd_n   (host_cmd_n),
    .cmd_wr  (cmd_wr),
    .data_wr (data_wr),
    .cmd_rd  (cmd_rd),
    .data_rd (data_rd)
  );

  cam_reg_loader #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_load (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .data_wr   (data_wr),
    .wdata     (host_wdata),
    .comparand (comparand_o),
    .mask_a    (mask_a_o),
    .mask_b    (mask_b_o),
    .ctrl      (ctrl_o),
    .cmp_mask  (cmp_mask_o),
    .wr_mask   (wr_mask_o),
    .cmp_req   (cmp_req)
  );

  cam_status_mux #(.DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_rd     (cmd_rd),
    .data_rd    (data_rd),
    .core_match (core_match),
    .core_multi (core_multi),
    .core_addr  (core_addr),
    .core_assoc (core_assoc),
    .rdata      (host_rdata)
  );

endmodule

// File: rtl/cam_host_if_chk.sv
module cam_host_if_chk #(
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              host_strobe,
  input logic              host_wr_n,
  input logic [BUS_W-1:0]  host_rdata,
  input logic              cmp_req,
  input logic [DATA_W-1:0] comparand_o,
  input logic [DATA_W-1:0] mask_a_o,
  input logic [DATA_W-1:0] mask_b_o,
  input logic [DATA_W-1:0] ctrl_o,
  input logic [DATA_W-1:0] wr_mask_o
);

  AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cmp_req |-> $past(host_strobe && !host_wr_n)); // R4

  AST_IDLE_HOLDS_REGS: assert property (@(posedge clk) disable iff (rst)
    !$past(host_strobe) |-> ($stable(comparand_o) && $stable(mask_a_o) &&
                             $stable(mask_b_o) && $stable(ctrl_o))); // R1

  AST_REG_CHANGE_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$stable(comparand_o) || !$stable(mask_a_o) ||
     !$stable(mask_b_o) || !$stable(ctrl_o)) |-> cmp_req); // R2

  AST_ONE_REG_PER_LOAD: assert property (@(posedge clk) disable iff (rst)
    $countones({!$stable(comparand_o), !$stable(mask_a_o),
                !$stable(mask_b_o), !$stable(ctrl_o)}) <= 1); // R6

  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !$past(host_strobe && host_wr_n) |-> $stable(host_rdata)); // R8

  AST_NO_WRITE_MASK: assert property (@(posedge clk) disable iff (rst)
    (ctrl_o[1:0] == 2'b00) |-> (wr_mask_o == '0)); // R10

endmodule

bind cam_host_if cam_host_if_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_strobe (host_strobe),
  .host_wr_n   (host_wr_n),
  .host_rdata  (host_rdata),
  .cmp_req     (cmp_req),
  .comparand_o (comparand_o),
  .mask_a_o    (mask_a_o),
  .mask_b_o    (mask_b_o),
  .ctrl_o      (ctrl_o),
  .wr_mask_o   (wr_mask_o)
);

// File: tb/tb_cam_host_if.sv
module tb_cam_host_if;

  localparam int DATA_W = 64;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_strobe = 1'b0;
  logic              host_wr_n = 1'b1;
  logic              host_cmd_n = 1'b1;
  logic [BUS_W-1:0]  host_wdata = '0;
  logic [BUS_W-1:0]  host_rdata;
  logic              cmp_req;
  logic [DATA_W-1:0] comparand_o, mask_a_o, mask_b_o, ctrl_o, cmp_mask_o, wr_mask_o;
  logic              core_match = 1'b0;
  logic              core_multi = 1'b0;
  logic [ADDR_W-1:0] core_addr = '0;
  logic [DATA_W-1:0] core_assoc = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DATA_W-1:0] expv [4];

  always #2 clk = ~clk;

  cam_host_if #(.DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed cycle; returns at the negedge after the capturing edge
  task automatic cyc(input logic wr_n, input logic cmd_n, input logic [15:0] d);
    @(negedge clk);
    host_strobe = 1'b1; host_wr_n = wr_n; host_cmd_n = cmd_n; host_wdata = d;
    @(negedge clk);
    host_strobe = 1'b0; host_wdata = 16'hDEAD;
  endtask

  function automatic logic [15:0] pat(input int t, input int k, input int s);
    return 16'(((t + 1) * 16'h1111) ^ (k * 16'h0F0F) ^ (s * 16'h2345));
  endfunction

  function automatic logic [63:0] regv(input int t);
    case (t)
      0: return comparand_o;
      1: return mask_a_o;
      2: return mask_b_o;
      default: return ctrl_o;
    endcase
  endfunction

  task automatic check_regs(input string req);
    for (int t = 0; t < 4; t++) chk(regv(t) === expv[t], req, regv(t), expv[t]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    for (int t = 0; t < 4; t++) expv[t] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check_regs("R11");
    chk(cmp_req === 1'b0, "R11", 64'(cmp_req), 0);
    chk(host_rdata === '0, "R11", 64'(host_rdata), 0);

    // R2 R3 R4 R6: full loads of every target, several seeds
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        cyc(1'b0, 1'b0, 16'(t + 1));
        v = '0;
        for (int k = 0; k < 4; k++) begin
          cyc(1'b0, 1'b1, pat(t, k, s));
          v[k*16 +: 16] = pat(t, k, s);
          if (k < 3) begin
            check_regs("R3");
            chk(cmp_req === 1'b0, "R4", 64'(cmp_req), 0);
          end
        end
        expv[t] = v;
        check_regs("R2");
        chk(cmp_req === 1'b1, "R4", 64'(cmp_req), 1);
        @(negedge clk);
        chk(cmp_req === 1'b0, "R4", 64'(cmp_req), 0);
      end
    end

    // R3: partial load discarded by a command write
    for (int n = 1; n < 4; n++) begin
      cyc(1'b0, 1'b0, 16'h0001);
      for (int k = 0; k < n; k++) cyc(1'b0, 1'b1, 16'hBAD0 + 16'(k));
      cyc(1'b0, 1'b0, 16'h0001);
      v = '0;
      for (int k = 0; k < 4; k++) begin
        cyc(1'b0, 1'b1, pat(n, k, 7));
        v[k*16 +: 16] = pat(n, k, 7);
      end
      expv[0] = v;
      check_regs("R3");
    end

    // R7: unknown code keeps target (mask B), no request, clears count
    cyc(1'b0, 1'b0, 16'h0003);
    cyc(1'b0, 1'b1, 16'hBBBB);
    cyc(1'b0, 1'b0, 16'h00FF);
    chk(cmp_req === 1'b0, "R7", 64'(cmp_req), 0);
    v = '0;
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b1, pat(2, k, 9));
      v[k*16 +: 16] = pat(2, k, 9);
    end
    expv[2] = v;
    check_regs("R7");

    // R5: explicit compare
    cyc(1'b0, 1'b0, 16'h0005);
    chk(cmp_req === 1'b1, "R5", 64'(cmp_req), 1);
    check_regs("R5");
    @(negedge clk);
    chk(cmp_req === 1'b0, "R5", 64'(cmp_req), 0);
    // target still mask B after compare code
    v = '0;
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b1, pat(2, k, 11));
      v[k*16 +: 16] = pat(2, k, 11);
    end
    expv[2] = v;
    check_regs("R5");

    // R1: strobe low, all line combinations, nothing changes
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      host_wr_n = c[1]; host_cmd_n = c[0]; host_wdata = 16'h0004;
      @(negedge clk);
      check_regs("R1");
      chk(cmp_req === 1'b0, "R1", 64'(cmp_req), 0);
      chk(host_rdata === '0, "R1", 64'(host_rdata), 0);
    end

    // R10: mask steering for every role combination
    for (int r = 0; r < 4; r++) begin
      logic [63:0] ec, ew;
      cyc(1'b0, 1'b0, 16'h0004);
      v = 64'(r);
      for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, v[k*16 +: 16]);
      expv[3] = v;
      ec = ((r & 1) ? 64'h0 : expv[1]) | ((r & 2) ? 64'h0 : expv[2]);
      ew = ((r & 1) ? expv[1] : 64'h0) | ((r & 2) ? expv[2] : 64'h0);
      chk(cmp_mask_o === ec, "R10", cmp_mask_o, ec);
      chk(wr_mask_o === ew, "R10", wr_mask_o, ew);
    end

    // R8: status sweep over every address and flag pair
    for (int a = 0; a < 1024; a++) begin
      logic [15:0] es;
      core_addr = 10'(a); core_match = a[0]; core_multi = a[1];
      cyc(1'b1, 1'b0, 16'h0);
      es = {a[0] ? 1'b1 : 1'b0, a[1] ? 1'b1 : 1'b0, 4'b0, 10'(a)};
      chk(host_rdata === es, "R8", 64'(host_rdata), 64'(es));
    end

    // R9: associated data words, wrap, restart on command write
    for (int s = 0; s < 3; s++) begin
      core_assoc = {pat(s, 3, 5), pat(s, 2, 5), pat(s, 1, 5), pat(s, 0, 5)};
      cyc(1'b0, 1'b0, 16'h00FF);
      for (int k = 0; k < 6; k++) begin
        cyc(1'b1, 1'b1, 16'h0);
        chk(host_rdata === core_assoc[(k % 4)*16 +: 16], "R9",
            64'(host_rdata), 64'(core_assoc[(k % 4)*16 +: 16]));
      end
      cyc(1'b0, 1'b0, 16'h0001);
      cyc(1'b1, 1'b1, 16'h0);
      chk(host_rdata === core_assoc[15:0], "R9", 64'(host_rdata), 64'(core_assoc[15:0]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule